// File: doc/BRIEF.md
# Debug Trace Capture Controller

This block records a history of CPU execution into a small on-chip circular trace memory for a debug unit. A control register holds a trace enable bit, a two-bit capture-filter field and a trigger placement bit. Write protection on that register depends on two status inputs, the secure flag and the block's own armed state. Software configures the register while the block is disarmed and then pulses an arm request. From that point each instruction-rate event on the event stream is tested against the selected filter. Events that pass are written into the buffer as packed entries.

The trigger pulse comes from comparator logic outside this block. With end placement (align bit 0) capture runs from arming. The trigger freezes the history and disarms the block, so the buffer holds the most recent entries that led up to the trigger. With start placement (align bit 1) storing begins on the trigger and ends once the buffer is full. After the session the buffer is read by index, where index 0 is the oldest stored entry. Readout is only allowed while trace enable is set and the block is disarmed.

Top module: `tcap_top`

## Requirements
- R1: After reset the control register reads 0x00, `armed` is 0 and `buf_count` is 0.
- R2: The register holds trace enable at bit 6, the mode at bits 3:2 and align at bit 0, and every other bit reads 0. A write changes bit 6 only while both `secure` and `armed` are low. Otherwise that bit keeps its value, so it can never be set while secure, and the other bits still follow R3.
- R3: A write changes mode and align only while `armed` is low. While armed the register does not change at all.
- R4: A `arm_req` pulse while disarmed sets `armed` in the next cycle and empties the buffer. A pulse while armed is ignored and leaves the stored entries untouched.
- R5: An entry is 34 bits: [33:32] is the mode, [31:16] is field A and [15:0] is field B. Mode 00 stores each valid event that has `ev_cof` set, with A = `ev_addr` and B = `ev_pc`.
- R6: Mode 01 works like mode 00, except that it skips an event whose `ev_addr` equals field A of the last entry stored since arming.
- R7: Mode 10 stores each valid event that has `ev_mem` set, with A = `ev_addr` and B = `ev_data`.
- R8: Mode 11 stores every valid event, with A = `ev_pc` and B = 0.
- R9: With align 0, storing starts in the cycle after arming. A trigger disarms the block, and the event in the trigger cycle is not stored. The buffer keeps only the newest 64 entries, `buf_count` saturates at 64, and index 0 reads the oldest entry kept.
- R10: With align 1, no event is stored before the trigger. The event in the trigger cycle is stored. The block disarms itself in the same cycle that it writes the 64th entry.
- R11: With trace enable 0, an armed session stores nothing, and the trigger disarms the block under either alignment.
- R12: No event is stored in a cycle where `secure` is high.
- R13: `buf_rd_ok` is high exactly when trace enable is 1 and `armed` is 0. While it is low, `buf_rd_data` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register read value |
| secure | input | 1 | System secured flag |
| arm_req | input | 1 | Arm request pulse |
| trig | input | 1 | Trigger pulse |
| ev_valid | input | 1 | Event present this cycle |
| ev_cof | input | 1 | Event is a change of flow |
| ev_mem | input | 1 | Event is a memory or register access |
| ev_addr | input | 16 | Target or access address |
| ev_data | input | 16 | Access data |
| ev_pc | input | 16 | Program counter of the instruction |
| armed | output | 1 | Session in progress |
| buf_rd_idx | input | 6 | Readout index, 0 = oldest |
| buf_rd_data | output | 34 | Entry at the readout index |
| buf_rd_ok | output | 1 | Readout permitted |
| buf_count | output | 7 | Number of entries held |

## Verification
The assertions check several rules on every cycle. They check the write protection of the enable bit and of the frozen mode and align fields. They check the readout gating, that the count stays within bounds, and that nothing changes the count while disarmed. They also check that a session with trace enable 0 stores nothing and that a start-aligned session never stays armed with a full buffer. Only the bench scenarios can show that the right events are kept in the right order. That covers each filter's selection and entry packing, the repeat suppression of mode 01, and wrap-around ordering under end alignment. It also covers the inclusive start of storing under start alignment, and which events are dropped during a secure window.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    TM_FLOW   = 2'b00,
    TM_LOOP   = 2'b01,
    TM_DETAIL = 2'b10,
    TM_PC     = 2'b11
  } tmode_e;

  localparam int TSRC_BIT  = 6;
  localparam int MODE_LSB  = 2;
  localparam int ALIGN_BIT = 0;
  localparam int REG_W     = 8;

  typedef struct packed {
    logic   tsrc;
    tmode_e mode;
    logic   align;
  } tcfg_t;
endpackage

// File: rtl/tcap_cfg_reg.sv
module tcap_cfg_reg
  import tcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             secure,
  input  logic             armed,
  output tcfg_t            cfg,
  output logic [REG_W-1:0] rdata
);
  tcfg_t cfg_q, cfg_d;
  logic  unused_wbits;

  assign unused_wbits = ^{wdata[7], wdata[5:4], wdata[1]};

  always_comb begin
    cfg_d = cfg_q;
    if (wr) begin
      if (!secure && !armed) cfg_d.tsrc = wdata[TSRC_BIT];
      if (!armed) begin
        cfg_d.mode  = tmode_e'(wdata[MODE_LSB +: 2]);
        cfg_d.align = wdata[ALIGN_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr) cfg_q <= cfg_d;
  end

  always_comb begin
    rdata                  = '0;
    rdata[TSRC_BIT]        = cfg_q.tsrc;
    rdata[MODE_LSB +: 2]   = cfg_q.mode;
    rdata[ALIGN_BIT]       = cfg_q.align;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/tcap_filter.sv
module tcap_filter
  import tcap_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int ENT_W = 2 + 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_en,
  input  tmode_e            mode,
  input  logic              ev_valid,
  input  logic              ev_cof,
  input  logic              ev_mem,
  input  logic [WORD_W-1:0] ev_addr,
  input  logic [WORD_W-1:0] ev_data,
  input  logic [WORD_W-1:0] ev_pc,
  output logic              store,
  output logic [ENT_W-1:0]  entry
);
  logic [WORD_W-1:0] last_q, last_d;
  logic              lvld_q, lvld_d;
  logic              hit;
  logic [WORD_W-1:0] fa, fb;

  always_comb begin
    hit = 1'b0;
    fa  = ev_addr;
    fb  = ev_pc;
    unique case (mode)
      TM_FLOW:   hit = ev_valid && ev_cof;
      TM_LOOP:   hit = ev_valid && ev_cof && (!lvld_q || (ev_addr != last_q));
      TM_DETAIL: begin
        hit = ev_valid && ev_mem;
        fb  = ev_data;
      end
      TM_PC: begin
        hit = ev_valid;
        fa  = ev_pc;
        fb  = '0;
      end
      default: hit = 1'b0;
    endcase
  end

  assign store = cap_en && hit;
  assign entry = {mode, fa, fb};

  always_comb begin
    last_d = last_q;
    lvld_d = lvld_q;
    if (clear) begin
      lvld_d = 1'b0;
    end else if (store) begin
      lvld_d = 1'b1;
      last_d = fa;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      lvld_q <= 1'b0;
    end else if (clear || store) begin
      last_q <= last_d;
      lvld_q <= lvld_d;
    end
  end
endmodule

// File: rtl/tcap_buffer.sv
module tcap_buffer #(
  parameter int ENT_W = 34,
  parameter int DL2   = 6,
  localparam int DEPTH = 1 << DL2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             we,
  input  logic [ENT_W-1:0] wdata,
  input  logic [DL2-1:0]   rd_idx,
  output logic [ENT_W-1:0] rd_data,
  output logic [DL2:0]     count,
  output logic             fill_done
);
  localparam logic [DL2:0]   FULL_CNT = (DL2 + 1)'(DEPTH);
  localparam logic [DL2-1:0] PTR_MAX  = '1;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [DL2-1:0]   wptr_q, wptr_d;
  logic             wrap_q, wrap_d;
  logic [DL2-1:0]   phys;

  always_comb begin
    wptr_d = wptr_q;
    wrap_d = wrap_q;
    if (clear) begin
      wptr_d = '0;
      wrap_d = 1'b0;
    end else if (we) begin
      wptr_d = wptr_q + 1'b1;
      if (wptr_q == PTR_MAX) wrap_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      wrap_q <= 1'b0;
    end else if (clear || we) begin
      wptr_q <= wptr_d;
      wrap_q <= wrap_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we && !clear) mem[wptr_q] <= wdata;
  end

  assign fill_done = we && !clear && (wptr_q == PTR_MAX);
  assign phys      = wrap_q ? (wptr_q + rd_idx) : rd_idx;
  assign rd_data   = mem[phys];
  assign count     = wrap_q ? FULL_CNT : {1'b0, wptr_q};
endmodule

// File: rtl/tcap_top.sv
module tcap_top
  import tcap_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DL2    = 6,
  localparam int ENT_W = 2 + 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              secure,
  input  logic              arm_req,
  input  logic              trig,
  input  logic              ev_valid,
  input  logic              ev_cof,
  input  logic              ev_mem,
  input  logic [WORD_W-1:0] ev_addr,
  input  logic [WORD_W-1:0] ev_data,
  input  logic [WORD_W-1:0] ev_pc,
  output logic              armed,
  input  logic [DL2-1:0]    buf_rd_idx,
  output logic [ENT_W-1:0]  buf_rd_data,
  output logic              buf_rd_ok,
  output logic [DL2:0]      buf_count
);
  tcfg_t            cfg;
  logic             armed_q, armed_d;
  logic             started_q, started_d;
  logic             clear, cap_en, store, fill_done;
  logic [ENT_W-1:0] entry, raw_rd;

  tcap_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .secure (secure),
    .armed  (armed_q),
    .cfg    (cfg),
    .rdata  (reg_rdata)
  );

  assign clear  = !armed_q && arm_req;
  assign cap_en = armed_q && cfg.tsrc && !secure &&
                  (cfg.align ? (started_q || trig) : !trig);

  tcap_filter #(.WORD_W(WORD_W)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .cap_en   (cap_en),
    .mode     (cfg.mode),
    .ev_valid (ev_valid),
    .ev_cof   (ev_cof),
    .ev_mem   (ev_mem),
    .ev_addr  (ev_addr),
    .ev_data  (ev_data),
    .ev_pc    (ev_pc),
    .store    (store),
    .entry    (entry)
  );

  tcap_buffer #(.ENT_W(ENT_W), .DL2(DL2)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .we        (store),
    .wdata     (entry),
    .rd_idx    (buf_rd_idx),
    .rd_data   (raw_rd),
    .count     (buf_count),
    .fill_done (fill_done)
  );

  always_comb begin
    armed_d   = armed_q;
    started_d = started_q;
    if (!armed_q) begin
      if (arm_req) begin
        armed_d   = 1'b1;
        started_d = 1'b0;
      end
    end else begin
      if (trig) started_d = 1'b1;
      if (trig && (!cfg.align || !cfg.tsrc)) armed_d = 1'b0;
      if (cfg.align && fill_done) armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      started_q <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      started_q <= started_d;
    end
  end

  assign armed       = armed_q;
  assign buf_rd_ok   = cfg.tsrc && !armed_q;
  assign buf_rd_data = buf_rd_ok ? raw_rd : '0;
endmodule

// File: rtl/tcap_checker.sv
module tcap_checker #(
  parameter int WORD_W = 16,
  parameter int DL2    = 6,
  localparam int ENT_W = 2 + 2 * WORD_W,
  localparam int DEPTH = 1 << DL2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       reg_rdata,
  input logic             secure,
  input logic             arm_req,
  input logic             armed,
  input logic [ENT_W-1:0] buf_rd_data,
  input logic             buf_rd_ok,
  input logic [DL2:0]     buf_count
);
  a_r2_tsrc_protected: assert property (@(posedge clk) disable iff (!rst_n)
    (secure || armed) |=> $stable(reg_rdata[6]));

  a_r2_no_set_when_secure: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[6]) |-> !$past(secure));

  a_r3_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(reg_rdata[3:2]) && $stable(reg_rdata[0])));

  a_r4_idle_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm_req) |=> $stable(buf_count));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    buf_count <= (DL2 + 1)'(DEPTH));

  a_r10_full_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_rdata[0]) |-> (buf_count < (DL2 + 1)'(DEPTH)));

  a_r11_no_store_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !reg_rdata[6]) |-> (buf_count == '0));

  a_r13_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_rd_ok |-> (buf_rd_data == '0));

  a_r13_ok_rule: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_ok == (reg_rdata[6] && !armed));
endmodule

bind tcap_top tcap_checker #(.WORD_W(WORD_W), .DL2(DL2)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rdata   (reg_rdata),
  .secure      (secure),
  .arm_req     (arm_req),
  .armed       (armed),
  .buf_rd_data (buf_rd_data),
  .buf_rd_ok   (buf_rd_ok),
  .buf_count   (buf_count)
);

// File: tb/tb_tcap_top.sv
module tb_tcap_top;
  logic        clk, rst_n;
  logic        reg_wr, secure, arm_req, trig;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        ev_valid, ev_cof, ev_mem;
  logic [15:0] ev_addr, ev_data, ev_pc;
  logic        armed, buf_rd_ok;
  logic [5:0]  buf_rd_idx;
  logic [33:0] buf_rd_data;
  logic [6:0]  buf_count;

  int tests, fails;
  logic [33:0] expq [0:255];
  int nexp;

  tcap_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .secure(secure), .arm_req(arm_req), .trig(trig),
    .ev_valid(ev_valid), .ev_cof(ev_cof), .ev_mem(ev_mem), .ev_addr(ev_addr),
    .ev_data(ev_data), .ev_pc(ev_pc), .armed(armed), .buf_rd_idx(buf_rd_idx),
    .buf_rd_data(buf_rd_data), .buf_rd_ok(buf_rd_ok), .buf_count(buf_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk);
    arm_req = 1'b1;
    @(negedge clk);
    arm_req = 1'b0;
  endtask

  task automatic drive_ev(input int k);
    ev_valid = ((k % 11) != 10);
    ev_cof   = ((k % 3) != 0);
    ev_mem   = ((k % 2) == 0);
    ev_addr  = 16'h2000 + 16'(k >> 1);
    ev_data  = 16'h5A5A ^ 16'(k * 7);
    ev_pc    = 16'h8000 + 16'(k);
  endtask

  task automatic run_session(input int mode, input int align, input int tsrc,
                             input int trig_at, input int nev,
                             input int sec_lo, input int sec_hi,
                             input int rearm_at, input string tag);
    bit m_armed, started, lvld, cap, hit, trg, sec;
    logic [15:0] last, fa, fb;
    int cnt, base;
    wr_reg({1'b0, 1'(tsrc), 2'b00, 2'(mode), 1'b0, 1'(align)});
    pulse_arm();
    m_armed = 1; started = 0; lvld = 0; nexp = 0;
    for (int k = 0; k < nev; k++) begin
      drive_ev(k);
      trg = (k == trig_at);
      sec = (k >= sec_lo) && (k < sec_hi);
      trig = trg; secure = sec;
      arm_req = (k == rearm_at);
      if (m_armed) begin
        cap = tsrc != 0 && !sec && ((align != 0) ? (started || trg) : !trg);
        if (trg) started = 1;
        fa = ev_addr; fb = ev_pc; hit = 0;
        case (mode)
          0: hit = ev_valid && ev_cof;
          1: hit = ev_valid && ev_cof && (!lvld || ev_addr != last);
          2: begin hit = ev_valid && ev_mem; fb = ev_data; end
          default: begin hit = ev_valid; fa = ev_pc; fb = 16'h0; end
        endcase
        if (cap && hit) begin
          expq[nexp] = {2'(mode), fa, fb};
          nexp++;
          lvld = 1; last = fa;
          if (align != 0 && nexp == 64) m_armed = 0;
        end
        if (trg && (align == 0 || tsrc == 0)) m_armed = 0;
      end
      @(negedge clk);
    end
    trig = 0; secure = 0; arm_req = 0; ev_valid = 0;
    @(negedge clk);
    @(negedge clk);
    check({tag, " R9 R10 R11 armed after session"}, 64'(armed), 64'(m_armed));
    cnt = (nexp > 64) ? 64 : nexp;
    check({tag, " R9 R11 count"}, 64'(buf_count), 64'(cnt));
    check({tag, " R13 rd_ok"}, 64'(buf_rd_ok), 64'(tsrc != 0 && !m_armed));
    base = (nexp > 64) ? nexp - 64 : 0;
    for (int i = 0; i < cnt; i++) begin
      buf_rd_idx = 6'(i);
      #1;
      check({tag, " R5 R6 R7 R8 entry"}, 64'(buf_rd_data), 64'(expq[base + i]));
    end
    buf_rd_idx = 0;
  endtask

  initial begin
    tests = 0; fails = 0;
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_wdata = 0; secure = 0; arm_req = 0; trig = 0;
    ev_valid = 0; ev_cof = 0; ev_mem = 0; ev_addr = 0; ev_data = 0; ev_pc = 0;
    buf_rd_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset reg", 64'(reg_rdata), 64'h00);
    check("R1 reset armed", 64'(armed), 64'h0);
    check("R1 reset count", 64'(buf_count), 64'h0);
    check("R13 rd_ok at reset", 64'(buf_rd_ok), 64'h0);

    // R2 R3: register layout and protection
    wr_reg(8'hFF);
    check("R2 layout all ones", 64'(reg_rdata), 64'h4D);
    secure = 1;
    wr_reg(8'h00);
    check("R2 tsrc held while secure", 64'(reg_rdata), 64'h40);
    wr_reg(8'h0D);
    check("R3 fields while secure", 64'(reg_rdata), 64'h4D);
    secure = 0;
    wr_reg(8'h00);
    check("R2 clear when open", 64'(reg_rdata), 64'h00);
    secure = 1;
    wr_reg(8'h40);
    check("R2 cannot set while secure", 64'(reg_rdata), 64'h00);
    secure = 0;

    // R3 R4: frozen while armed, arm clears buffer
    wr_reg(8'h4C);
    pulse_arm();
    check("R4 armed after pulse", 64'(armed), 64'h1);
    wr_reg(8'h01);
    check("R3 frozen while armed", 64'(reg_rdata), 64'h4C);
    check("R13 no read while armed", 64'(buf_rd_ok), 64'h0);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    check("R9 trigger disarms", 64'(armed), 64'h0);

    // sweep of filters and alignments
    for (int m = 0; m < 4; m++) begin
      run_session(m, 0, 1, 150, 160, -1, -1, -1, $sformatf("m%0d end", m));
      run_session(m, 1, 1, 20, 230, -1, -1, -1, $sformatf("m%0d start", m));
    end
    // R11: tracing disabled
    run_session(0, 1, 0, 30, 40, -1, -1, -1, "R11 off start");
    check("R11 rd_data zero", 64'(buf_rd_data), 64'h0);
    run_session(3, 0, 0, 30, 40, -1, -1, -1, "R11 off end");
    // R12 secure window and R4 ignored re-arm
    run_session(0, 0, 1, 120, 130, 40, 80, 90, "R12 R4 secure rearm");
    run_session(3, 0, 1, 50, 60, 10, 20, 30, "R12 R4 pc window");
    // R4: re-arm empties the buffer
    pulse_arm();
    check("R4 arm empties buffer", 64'(buf_count), 64'h0);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule